// File: doc/BRIEF.md
# Shared Reset Pin Sequencer

This block owns an active-low, open-drain reset pin that the chip shares with board-level circuitry. When an internal reset source requests a reset, the block enables the pin's low driver for a fixed number of system clocks and then lets go. It does not leave hardware reset at once. It watches the pin and keeps the chip's internal hardware reset asserted while anything outside still pulls the pin low. A board supervisor can therefore lengthen the reset as far as it needs.

The block also accepts resets applied from outside. The pin is brought into the clock domain through a flop synchronizer. A digital filter then rejects low pulses shorter than a minimum width. A bypass input switches the filter out so that the synchronized level is used directly. An accepted external pulse starts the same timed drive sequence as an internal request. A sticky status flag records each completed pin reset and is cleared by a one-cycle clear strobe.

Top module: `rstpin_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `pin_drive_en`, `hw_rst` and `pin_rst_flag` are all 0.
- R2: A high `int_req` sampled at a clock edge while the block is idle raises `pin_drive_en` after that edge. `pin_drive_en` then stays at 1 for exactly DRIVE_CYCLES (default 1024) consecutive cycles.
- R3: After the drive phase, `pin_drive_en` stays at 0 until a new sequence starts, even while the pin is still low.
- R4: `hw_rst` is 1 from the first drive cycle until the filtered pin level is seen high after release. It stays at 1 for as long as an external source holds the pin low.
- R5: When the filtered pin is seen high after release, `hw_rst` falls and `pin_rst_flag` becomes 1 at the same edge. The flag then stays at 1 with no further input.
- R6: A high `clr_flag` at an edge clears `pin_rst_flag`, except at the edge where a sequence completes. There the set wins and the flag reads 1.
- R7: With `filt_bypass` = 0, an external low counts as a reset only if the synchronized pin reads 0 on at least MIN_LOW (default 4) consecutive edges. A pin held low for 3 cycles, or for 1 cycle, starts nothing.
- R8: With `filt_bypass` = 1, a low lasting a single clock cycle on `pin_in` is accepted as an external reset.
- R9: An accepted external reset runs the same sequence as an internal request: exactly DRIVE_CYCLES cycles of drive, then a wait for the pin to read high.
- R10: Requests from `int_req` or from the pin that arrive while a sequence is running are ignored and do not lengthen the drive phase.
- R11: With the bypass active, `pin_in` passes through SYNC_STAGES (default 2) flops. A low applied just before edge k raises `pin_drive_en` after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer |
| int_req | input | 1 | Internal reset request, sampled each cycle |
| pin_in | input | 1 | Level read back from the shared reset pin (0 = low) |
| filt_bypass | input | 1 | 1 removes the width filter from the pin path |
| clr_flag | input | 1 | Clear strobe for the status flag |
| pin_drive_en | output | 1 | 1 enables the pad's low driver; 0 leaves the pin to its pull-up |
| hw_rst | output | 1 | Internal hardware reset, active high |
| pin_rst_flag | output | 1 | Sticky flag: a pin reset sequence has completed |

## Verification
The assertions assume that `pin_in` reads low whenever `pin_drive_en` is 1, as a real open-drain pad does. The bench therefore models the pin as the wired-AND of the block's own driver and an external holder, and never feeds back a high level while the driver is on. The assertions also assume that `clr_flag` is the only way to clear the flag apart from `rst_n`. External pulses and clear strobes are applied between edges and held for whole cycles. This keeps the filter's cycle counts exact, and a behavioural model that steps once per clock predicts every output.

// File: rtl/rstpin_pkg.sv
// Shared definitions for the reset pin sequencer.
// Assumes the FSM encoding is one-hot; bit positions are fixed here.
package rstpin_pkg;

    localparam int ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE  = 3'b001,
        ST_DRIVE = 3'b010,
        ST_WAIT  = 3'b100
    } seq_state_e;

endpackage

// File: rtl/rstpin_sync.sv
// Multi-flop synchronizer for the pin read-back.
// Assumes d is asynchronous to clk; q follows d after STAGES edges.
// The reset value is the idle (released) level of the pin.
module rstpin_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Purpose: single capture flop
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= RESET_VAL;
                else        chain_q <= d;
            end
        end else begin : g_chain
            // Purpose: shift the pin level through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rstpin_filter.sv
// Width filter for the synchronized pin level.
// The stored level changes only after the input has differed from it
// on MIN_LOW consecutive edges. With bypass set, the raw synchronized
// level is used instead. Also flags a falling edge of the used level.
// Assumes raw is already synchronous to clk.
module rstpin_filter #(
    parameter int MIN_LOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic bypass,
    output logic level,
    output logic fall
);

    localparam int              CW   = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0]   LAST = CW'(MIN_LOW - 1);

    logic          lvl_q;
    logic [CW-1:0] run_q;
    logic          prev_q;

    // Purpose: saturating run counter that moves the stored level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b1;
            run_q <= '0;
        end else if (raw == lvl_q) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            lvl_q <= raw;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // Purpose: pick the filtered or the bypassed level
    always_comb begin
        level = bypass ? raw : lvl_q;
    end

    // Purpose: remember the last used level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= level;
    end

    assign fall = prev_q & ~level;

endmodule

// File: rtl/rstpin_fsm.sv
// Sequencing FSM: IDLE -> DRIVE for DRIVE_CYCLES cycles -> WAIT until
// the pin reads high -> IDLE. Sets a sticky flag on completion.
// Assumes start is ignored outside IDLE and that level is the filtered
// pin value. All outputs are decoded from registered state.
module rstpin_fsm
    import rstpin_pkg::*;
#(
    parameter int DRIVE_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic level,
    input  logic clr,
    output logic drive_en,
    output logic hw_rst,
    output logic flag
);

    localparam int              CNT_W = (DRIVE_CYCLES > 1) ? $clog2(DRIVE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DRIVE_CYCLES - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             done;

    // Purpose: next-state decision
    always_comb begin
        state_d = state_q;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_DRIVE;
            ST_DRIVE: if (cnt_q == CNT_LAST) state_d = ST_WAIT;
            ST_WAIT: begin
                if (level) begin
                    state_d = ST_IDLE;
                    done    = 1'b1;
                end
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // Purpose: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Purpose: drive-phase cycle counter, cleared outside DRIVE
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_DRIVE) cnt_q <= '0;
        else                               cnt_q <= cnt_q + 1'b1;
    end

    // Purpose: sticky completion flag, set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (done) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    assign drive_en = state_q[1];
    assign hw_rst   = ~state_q[0];

endmodule

// File: rtl/rstpin_seq.sv
// Top of the shared reset pin sequencer.
// Assumes pin_in is the pad read-back (low while pin_drive_en is 1) and
// asynchronous to clk. Joins synchronizer, filter and FSM.
module rstpin_seq #(
    parameter int DRIVE_CYCLES = 1024,
    parameter int MIN_LOW      = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic int_req,
    input  logic pin_in,
    input  logic filt_bypass,
    input  logic clr_flag,
    output logic pin_drive_en,
    output logic hw_rst,
    output logic pin_rst_flag
);

    logic pin_sync;
    logic pin_level;
    logic pin_fall;
    logic start_req;

    rstpin_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    rstpin_filter #(
        .MIN_LOW (MIN_LOW)
    ) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pin_sync),
        .bypass (filt_bypass),
        .level  (pin_level),
        .fall   (pin_fall)
    );

    // Purpose: either source may start a sequence
    always_comb begin
        start_req = int_req | pin_fall;
    end

    rstpin_fsm #(
        .DRIVE_CYCLES (DRIVE_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_req),
        .level    (pin_level),
        .clr      (clr_flag),
        .drive_en (pin_drive_en),
        .hw_rst   (hw_rst),
        .flag     (pin_rst_flag)
    );

endmodule

// File: rtl/rstpin_chk.sv
// Assertion checker for rstpin_seq, attached by bind.
// Assumes the pad reads low while the driver is enabled.
module rstpin_chk #(
    parameter int DRIVE_CYCLES = 1024
) (
    input logic clk,
    input logic rst_n,
    input logic clr_flag,
    input logic pin_drive_en,
    input logic hw_rst,
    input logic pin_rst_flag
);

    localparam int RW = $clog2(DRIVE_CYCLES + 1) + 1;

    logic [RW-1:0] run_q;

    // Purpose: count consecutive drive cycles
    always_ff @(posedge clk) begin
        if (!rst_n)            run_q <= '0;
        else if (pin_drive_en) run_q <= run_q + 1'b1;
        else                   run_q <= '0;
    end

    // R2
    drive_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_drive_en) |-> run_q == RW'(DRIVE_CYCLES));

    // R10
    drive_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_drive_en |-> run_q < RW'(DRIVE_CYCLES));

    // R4
    drive_in_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_drive_en |-> hw_rst);

    // R3
    rst_end_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hw_rst) |-> !$past(pin_drive_en));

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_rst_flag) |-> $fell(hw_rst));

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_rst_flag) |-> $past(clr_flag));

endmodule

bind rstpin_seq rstpin_chk #(
    .DRIVE_CYCLES (DRIVE_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_flag     (clr_flag),
    .pin_drive_en (pin_drive_en),
    .hw_rst       (hw_rst),
    .pin_rst_flag (pin_rst_flag)
);

// File: tb/rstpin_seq_test.sv
module rstpin_seq_test;

    localparam int NDRV = 1024;
    localparam int NMIN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic int_req = 1'b0;
    logic ext_hold = 1'b0;
    logic filt_bypass = 1'b0;
    logic clr_flag = 1'b0;
    logic pin_in;
    logic pin_drive_en, hw_rst, pin_rst_flag;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit cmp_en = 1'b0;

    // wired-AND pad: own driver or external holder pulls low
    assign pin_in = ~(pin_drive_en | ext_hold);

    rstpin_seq uut (
        .clk(clk), .rst_n(rst_n), .int_req(int_req), .pin_in(pin_in),
        .filt_bypass(filt_bypass), .clr_flag(clr_flag),
        .pin_drive_en(pin_drive_en), .hw_rst(hw_rst), .pin_rst_flag(pin_rst_flag)
    );

    always #5 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    bit s_rst = 0, s_req = 0, s_pin = 1, s_byp = 0, s_clr = 0;
    bit sync_q[$] = '{1'b1, 1'b1};
    bit m_lvl = 1, m_prev = 1;
    int m_run = 0;
    int m_mode = 0;   // 0 idle, 1 driving, 2 waiting
    int m_cnt = 0;
    bit m_flag = 0;

    always @(posedge clk) begin : model_step
        bit f, fall, fin;
        cycles++;
        if (!s_rst) begin
            sync_q = '{1'b1, 1'b1};
            m_lvl = 1; m_prev = 1; m_run = 0;
            m_mode = 0; m_cnt = 0; m_flag = 0;
        end else begin
            f = s_byp ? sync_q[$] : m_lvl;
            fall = m_prev && !f;
            fin = 0;
            if (m_mode == 0) begin
                if (s_req || fall) begin m_mode = 1; m_cnt = 0; end
            end else if (m_mode == 1) begin
                m_cnt++;
                if (m_cnt == NDRV) m_mode = 2;
            end else if (f) begin
                m_mode = 0; fin = 1;
            end
            if (fin) m_flag = 1;
            else if (s_clr) m_flag = 0;
            m_prev = f;
            if (sync_q[$] == m_lvl) m_run = 0;
            else if (m_run + 1 == NMIN) begin m_lvl = sync_q[$]; m_run = 0; end
            else m_run++;
            void'(sync_q.pop_back());
            sync_q.push_front(s_pin);
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // compare every cycle, then snapshot inputs for the next edge
    always @(negedge clk) begin
        #2;
        if (cmp_en) begin
            check(pin_drive_en == (m_mode == 1), "R2 drive vs model", pin_drive_en, m_mode == 1);
            check(hw_rst == (m_mode != 0), "R4 hw_rst vs model", hw_rst, m_mode != 0);
            check(pin_rst_flag == m_flag, "R5 flag vs model", pin_rst_flag, m_flag);
        end
        s_rst = rst_n; s_req = int_req; s_pin = pin_in;
        s_byp = filt_bypass; s_clr = clr_flag;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic pulse_req();
        @(negedge clk) int_req = 1'b1;
        @(negedge clk) int_req = 1'b0;
    endtask

    task automatic ext_pulse(int n);
        @(negedge clk) ext_hold = 1'b1;
        repeat (n) @(negedge clk);
        ext_hold = 1'b0;
    endtask

    task automatic wait_drive(output bit seen);
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            if (pin_drive_en) begin seen = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic measure_drive(output int n, input bit mid_req);
        n = 0;
        while (pin_drive_en && n < 5000) begin
            n++;
            if (mid_req && n == 500) int_req = 1'b1;
            else int_req = 1'b0;
            @(negedge clk);
        end
        int_req = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (hw_rst && n < 2000) begin n++; @(negedge clk); end
    endtask

    task automatic clear_flag();
        @(negedge clk) clr_flag = 1'b1;
        @(negedge clk) clr_flag = 1'b0;
    endtask

    initial begin
        bit seen;
        int n;
        repeat (3) @(negedge clk);
        cmp_en = 1'b1;
        // R1 reset state while held
        check(!pin_drive_en && !hw_rst && !pin_rst_flag, "R1 outputs in reset",
              {pin_drive_en, hw_rst, pin_rst_flag}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!pin_drive_en && !hw_rst && !pin_rst_flag, "R1 outputs after release",
              {pin_drive_en, hw_rst, pin_rst_flag}, 0);
        repeat (5) @(negedge clk);

        // R2 / R10: internal request, second request mid-drive ignored
        pulse_req();
        check(pin_drive_en == 1, "R2 drive starts after request", pin_drive_en, 1);
        measure_drive(n, 1'b1);
        check(n == NDRV, "R2 R10 drive length", n, NDRV);
        check(pin_drive_en == 0, "R3 driver released", pin_drive_en, 0);
        wait_idle(n);
        check(!hw_rst && pin_rst_flag, "R5 completion sets flag", pin_rst_flag, 1);
        repeat (50) @(negedge clk);
        check(pin_rst_flag == 1, "R5 flag sticky", pin_rst_flag, 1);
        check(pin_drive_en == 0, "R10 no restart after ignored request", pin_drive_en, 0);
        clear_flag();
        check(pin_rst_flag == 0, "R6 clear strobe", pin_rst_flag, 0);

        // R4 / R3: external holder stretches the reset
        pulse_req();
        ext_hold = 1'b1;
        measure_drive(n, 1'b0);
        check(n == NDRV, "R2 drive length with holder", n, NDRV);
        repeat (300) @(negedge clk);
        check(hw_rst == 1, "R4 reset held by external low", hw_rst, 1);
        check(pin_drive_en == 0, "R3 no redrive while pin low", pin_drive_en, 0);
        check(pin_rst_flag == 0, "R5 flag not set while held", pin_rst_flag, 0);
        ext_hold = 1'b0;
        wait_idle(n);
        check(n < 20 && !hw_rst, "R4 reset ends after release", n, 0);
        check(pin_rst_flag == 1, "R5 flag after stretched reset", pin_rst_flag, 1);
        clear_flag();

        // R7: short pulses rejected by the filter
        filt_bypass = 1'b0;
        ext_pulse(3);
        wait_drive(seen);
        check(!seen && !hw_rst, "R7 three-cycle pulse rejected", seen, 0);
        ext_pulse(1);
        wait_drive(seen);
        check(!seen, "R7 one-cycle pulse rejected", seen, 0);

        // R7 / R9: minimum-width pulse accepted, full sequence
        ext_pulse(NMIN);
        wait_drive(seen);
        check(seen, "R7 four-cycle pulse accepted", seen, 1);
        measure_drive(n, 1'b0);
        check(n == NDRV, "R9 external drive length", n, NDRV);
        wait_idle(n);
        check(pin_rst_flag == 1, "R9 external sequence completes", pin_rst_flag, 1);

        // R6: set wins over a simultaneous clear
        @(negedge clk) clr_flag = 1'b1;
        pulse_req();
        measure_drive(n, 1'b0);
        wait_idle(n);
        check(pin_rst_flag == 1, "R6 set wins over clear", pin_rst_flag, 1);
        @(negedge clk);
        check(pin_rst_flag == 0, "R6 clear after completion", pin_rst_flag, 0);
        clr_flag = 1'b0;

        // R8 / R11: bypass accepts a single cycle, latency of sync chain
        @(negedge clk) filt_bypass = 1'b1;
        repeat (3) @(negedge clk);
        @(negedge clk) ext_hold = 1'b1;
        @(negedge clk) ext_hold = 1'b0;
        check(pin_drive_en == 0, "R11 no drive after first edge", pin_drive_en, 0);
        @(negedge clk);
        check(pin_drive_en == 0, "R11 no drive after second edge", pin_drive_en, 0);
        @(negedge clk);
        check(pin_drive_en == 1, "R8 R11 drive after third edge", pin_drive_en, 1);
        measure_drive(n, 1'b0);
        check(n == NDRV, "R8 bypass drive length", n, NDRV);
        wait_idle(n);
        check(!hw_rst, "R8 bypass sequence completes", hw_rst, 0);

        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule